// File: doc/BRIEF.md
# Latched-Update Pulse-Width Modulator

A single-channel pulse-width modulator controlled through four word registers on a simple read/write register bus. A free-running counter runs from 0 to period-1 at the input clock rate, a fixed prescale of one. In left-aligned mode the output holds its active level while the count is below the duty value, and holds its idle level for the rest of each period. The active level and the idle level are chosen by two separate control bits. Normal polarity gives a high active level and a low idle level. Inverted polarity gives a low active level and a high idle level.

Software writes to period and duty land in shadow registers. Shadow values and the polarity bits move into the live waveform only at a period boundary, so a period never mixes old and new settings. A hold bit in the control register blocks that move entirely. Software sets the hold bit, rewrites period and duty, then clears it in the same control write that carries the new polarity. All three then take effect together at the start of the following period.

Top module: `pwm_latched`

## Requirements
- R1: After reset every register reads 0, the channel is stopped and the output is low.
- R2: Word registers are selected by address bits [3:2]: count at byte offset 0x0 (read-only, writes ignored), period at 0x4, duty at 0x8, control at 0xC. Period and duty read back the last written shadow value. Control reads back only bits 0, 1, 3, 4, 5, 6 and 8; all other bits read 0.
- R3: The channel runs only when control bit 0 (enable) = 1, bit 1 (continuous) = 1, bit 5 (alignment) = 0 and bit 8 (low-power) = 0. Otherwise the counter returns to 0 and the output shows the idle level.
- R4: While running, the counter advances by one each clock and wraps from period-1 to 0. A read at offset 0x0 returns the live count.
- R5: While running, the output equals the active level when count < duty and the idle level otherwise.
- R6: Control bit 3 is the active level and bit 4 is the idle level (1 = high).
- R7: A duty of 0 gives a constant idle level. A duty at or above the period gives a constant active level. A period of 0 gives a constant idle level.
- R8: With control bit 6 (hold) clear, new period, duty and polarity reach the waveform only at the next wrap to 0. While stopped, they are taken on the next clock.
- R9: While the hold bit is set, writes to period, duty and the polarity bits leave the waveform unchanged.
- R10: Clearing the hold bit makes period, duty and polarity take effect together at the next period boundary.
- R11: A read request returns its data with the read-valid flag one clock later. The flag is low in cycles that follow no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address; bits [3:2] pick the word |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one clock after bus_rd_i |
| pwm_o | output | 1 | Modulated output |

## Verification
The assertions assume that each bus access is a single-cycle strobe to a word-aligned address, with read and write never asserted together. They also assume that reset is released away from the clock edge. The bench drives every access from one task: the task raises a single strobe on a falling edge and drops it on the next falling edge, so accesses never overlap. A reference model built from the requirements predicts the output on every cycle. This includes writes that land in the middle of a period and a hold bit that is toggled while the counter runs.

// File: rtl/pwm_latched_pkg.sv
package pwm_latched_pkg;

    // word index taken from address bits [3:2]
    localparam logic [1:0] REG_CNT  = 2'd0;
    localparam logic [1:0] REG_PER  = 2'd1;
    localparam logic [1:0] REG_DUTY = 2'd2;
    localparam logic [1:0] REG_CTRL = 2'd3;

    // control bit positions
    localparam int CB_EN     = 0;
    localparam int CB_CONT   = 1;
    localparam int CB_ACT    = 3;
    localparam int CB_IDLE   = 4;
    localparam int CB_ALIGN  = 5;
    localparam int CB_HOLD   = 6;
    localparam int CB_LOWPWR = 8;

    localparam int CTRL_W = 9;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 9'h17B;

    typedef struct packed {
        logic run;
        logic hold;
        logic act_lvl;
        logic idle_lvl;
    } cfg_view_t;

    function automatic logic run_decode(input logic [CTRL_W-1:0] c);
        return c[CB_EN] & c[CB_CONT] & ~c[CB_ALIGN] & ~c[CB_LOWPWR];
    endfunction

endpackage

// File: rtl/pwm_latched_regs.sv
module pwm_latched_regs
    import pwm_latched_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [DATA_W-1:0] cnt_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic [DATA_W-1:0] shd_per_o,
    output logic [DATA_W-1:0] shd_duty_o,
    output cfg_view_t         cfg_o
);

    localparam int WORD_LSB = 2;

    typedef struct packed {
        logic [DATA_W-1:0] per;
        logic [DATA_W-1:0] duty;
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } regs_t;

    regs_t st_d, st_q;
    logic [1:0] word_sel;

    assign word_sel = bus_addr_i[WORD_LSB +: 2];

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_rd_i;
        if (bus_wr_i) begin
            case (word_sel)
                REG_PER:  st_d.per  = bus_wdata_i;
                REG_DUTY: st_d.duty = bus_wdata_i;
                REG_CTRL: st_d.ctrl = bus_wdata_i[CTRL_W-1:0] & CTRL_MASK;
                default:  ;
            endcase
        end
        if (bus_rd_i) begin
            case (word_sel)
                REG_CNT:  st_d.rdata = cnt_i;
                REG_PER:  st_d.rdata = st_q.per;
                REG_DUTY: st_d.rdata = st_q.duty;
                default:  st_d.rdata = DATA_W'(st_q.ctrl);
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o    = st_q.rdata;
    assign bus_rvalid_o   = st_q.rvalid;
    assign shd_per_o      = st_q.per;
    assign shd_duty_o     = st_q.duty;
    assign cfg_o.run      = run_decode(st_q.ctrl);
    assign cfg_o.hold     = st_q.ctrl[CB_HOLD];
    assign cfg_o.act_lvl  = st_q.ctrl[CB_ACT];
    assign cfg_o.idle_lvl = st_q.ctrl[CB_IDLE];

    // R11: read data arrives one clock after the request
    a_r11_rvalid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rd_i |=> bus_rvalid_o);
    a_r11_rvalid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_rd_i |=> !bus_rvalid_o);
    // R2: unused control bits never read back as set
    a_r2_ctrl_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && word_sel == REG_CTRL) |=> ((bus_rdata_o & ~DATA_W'(CTRL_MASK)) == '0));

endmodule

// File: rtl/pwm_latched_core.sv
module pwm_latched_core
    import pwm_latched_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] shd_per_i,
    input  logic [CNT_W-1:0] shd_duty_i,
    input  cfg_view_t        cfg_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pwm_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic             act;
        logic             idle;
        logic             run;
    } core_t;

    core_t st_d, st_q;
    logic  wrap;
    logic  load;

    always_comb begin
        wrap     = (st_q.per == '0) || (st_q.cnt == st_q.per - CNT_W'(1));
        load     = !cfg_i.hold && (!st_q.run || wrap);
        st_d     = st_q;
        st_d.run = cfg_i.run;
        if (!st_q.run || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (load) begin
            st_d.per  = shd_per_i;
            st_d.duty = shd_duty_i;
            st_d.act  = cfg_i.act_lvl;
            st_d.idle = cfg_i.idle_lvl;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign pwm_o = (st_q.run && st_q.per != '0 && st_q.cnt < st_q.duty) ? st_q.act : st_q.idle;

    // R4: count stays inside the live period
    a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run && st_q.per != '0) |-> (st_q.cnt < st_q.per));
    // R3: a stopped channel settles its counter to zero
    a_r3_stopped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.run |=> (st_q.cnt == '0));
    // R8: no live change in the middle of a period
    a_r8_mid_period_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run && st_q.per != '0 && st_q.cnt != st_q.per - CNT_W'(1))
        |=> ($stable(st_q.per) && $stable(st_q.duty) && $stable(st_q.act) && $stable(st_q.idle)));
    // R9: hold freezes every live setting
    a_r9_hold_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_i.hold |=> ($stable(st_q.per) && $stable(st_q.duty) && $stable(st_q.act) && $stable(st_q.idle)));
    // R7: zero duty shows only the idle level
    a_r7_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.duty == '0) |-> (pwm_o == st_q.idle));
    // R7: full duty shows only the active level
    a_r7_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run && st_q.per != '0 && st_q.duty >= st_q.per) |-> (pwm_o == st_q.act));

endmodule

// File: rtl/pwm_latched.sv
module pwm_latched
    import pwm_latched_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              pwm_o
);

    logic [DATA_W-1:0] shd_per;
    logic [DATA_W-1:0] shd_duty;
    logic [DATA_W-1:0] live_cnt;
    cfg_view_t         cfg;

    pwm_latched_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .bus_wr_i     (bus_wr_i),
        .bus_rd_i     (bus_rd_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .cnt_i        (live_cnt),
        .bus_rdata_o  (bus_rdata_o),
        .bus_rvalid_o (bus_rvalid_o),
        .shd_per_o    (shd_per),
        .shd_duty_o   (shd_duty),
        .cfg_o        (cfg)
    );

    pwm_latched_core #(
        .CNT_W (DATA_W)
    ) core_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .shd_per_i  (shd_per),
        .shd_duty_i (shd_duty),
        .cfg_i      (cfg),
        .cnt_o      (live_cnt),
        .pwm_o      (pwm_o)
    );

endmodule

// File: tb/pwm_latched_tb_top.sv
module pwm_latched_tb_top;

    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          pwm;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    logic  wave_on = 1'b0;
    logic  finished = 1'b0;

    always #4 clk = ~clk;

    pwm_latched #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .bus_wr_i     (wr),
        .bus_rd_i     (rd),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid),
        .pwm_o        (pwm)
    );

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // reference model written from the requirements
    logic [DW-1:0] m_per, m_duty, m_cnt, m_lper, m_lduty;
    logic [8:0]    m_ctrl;
    logic          m_run, m_lact, m_lidle;

    always @(posedge clk) begin : ref_model
        logic going, at_end, take;
        if (!rst_n) begin
            m_per <= '0; m_duty <= '0; m_cnt <= '0; m_lper <= '0; m_lduty <= '0;
            m_ctrl <= '0; m_run <= 1'b0; m_lact <= 1'b0; m_lidle <= 1'b0;
        end else begin
            going  = m_run;
            at_end = (m_lper == 0) || (m_cnt + 1 == m_lper);
            take   = !m_ctrl[6] && (!going || at_end);
            m_run  <= m_ctrl[0] && m_ctrl[1] && !m_ctrl[5] && !m_ctrl[8];
            m_cnt  <= (going && !at_end) ? m_cnt + 1 : '0;
            if (take) begin
                m_lper  <= m_per;
                m_lduty <= m_duty;
                m_lact  <= m_ctrl[3];
                m_lidle <= m_ctrl[4];
            end
            if (wr) begin
                case (addr[3:2])
                    2'd1: m_per  <= wdata;
                    2'd2: m_duty <= wdata;
                    2'd3: m_ctrl <= wdata[8:0] & 9'h17B;
                    default: ;
                endcase
            end
        end
    end

    // waveform monitor
    always @(negedge clk) begin : wave_mon
        logic e;
        if (wave_on) begin
            e = (m_run && m_lper != 0 && m_cnt < m_lduty) ? m_lact : m_lidle;
            chk("pwm level", DW'(pwm), DW'(e));
        end
    end

    // read scoreboard
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always @(negedge clk) begin : rd_mon
        logic [DW-1:0] e;
        string         saved;
        if (rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL %s unexpected read data: actual %h expected none", tag, rdata);
            end else begin
                e = exp_q.pop_front();
                saved = tag;
                tag = tag_q.pop_front();
                chk("read data", rdata, e);
                tag = saved;
            end
        end
    end

    task automatic bus_write(input logic [1:0] w, input logic [DW-1:0] v);
        @(negedge clk);
        wr = 1'b1; addr = {w, 2'b00}; wdata = v;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] w);
        logic [DW-1:0] e;
        @(negedge clk);
        case (w)
            2'd0: e = m_cnt;
            2'd1: e = m_per;
            2'd2: e = m_duty;
            default: e = DW'(m_ctrl);
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd = 1'b1; addr = {w, 2'b00};
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        // R11: valid one clock after the request
        chk("R11 read valid", DW'(rvalid), DW'(1));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 output after reset", DW'(pwm), DW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        wave_on = 1'b1;
        tag = "R1";
        for (int w = 0; w < 4; w++) bus_read(2'(w));

        // R2: register map and readback
        tag = "R2";
        bus_write(2'd1, 32'h1234_5678);
        bus_write(2'd2, 32'hA5A5_0F0F);
        bus_write(2'd3, 32'hFFFF_FFFF);
        bus_write(2'd0, 32'h0000_BEEF);
        bus_read(2'd1);
        bus_read(2'd2);
        bus_read(2'd3);
        bus_read(2'd0);
        chk("R2 ctrl mask model", DW'(m_ctrl), 32'h0000_017B);
        bus_write(2'd3, 32'h0);

        // R4 R5: normal run
        tag = "R4";
        bus_write(2'd1, 10);
        bus_write(2'd2, 3);
        bus_write(2'd3, 32'h0B);
        idle(7);
        bus_read(2'd0);
        idle(4);
        bus_read(2'd0);
        tag = "R5";
        idle(25);

        // R6: inverted levels
        tag = "R6";
        bus_write(2'd3, 32'h13);
        idle(25);
        bus_write(2'd3, 32'h1B);
        idle(25);

        // R3: run decode
        tag = "R3";
        bus_write(2'd3, 32'h2B);
        idle(12);
        bus_read(2'd0);
        bus_write(2'd3, 32'h10B);
        idle(12);
        bus_write(2'd3, 32'h1A);
        idle(12);
        bus_write(2'd3, 32'h19);
        idle(12);
        bus_write(2'd3, 32'h0B);
        idle(15);

        // R7: edge duty and period values
        tag = "R7";
        bus_write(2'd2, 0);
        idle(22);
        bus_write(2'd2, 10);
        idle(22);
        bus_write(2'd2, 50);
        idle(22);
        bus_write(2'd1, 0);
        idle(22);

        // R8: updates mid period
        tag = "R8";
        bus_write(2'd1, 8);
        bus_write(2'd2, 2);
        idle(13);
        bus_write(2'd2, 6);
        idle(3);
        bus_write(2'd1, 5);
        idle(20);

        // R9: hold blocks everything
        tag = "R9";
        bus_write(2'd3, 32'h4B);
        bus_write(2'd1, 12);
        bus_write(2'd2, 9);
        idle(30);
        bus_write(2'd3, 32'h53);
        idle(30);

        // R10: release with new polarity
        tag = "R10";
        bus_write(2'd3, 32'h13);
        idle(40);
        bus_write(2'd3, 32'h4B);
        bus_write(2'd1, 7);
        bus_write(2'd2, 1);
        idle(9);
        bus_write(2'd3, 32'h0B);
        idle(30);

        tag = "R11";
        bus_read(2'd3);
        idle(2);
        chk("R11 valid drops", DW'(rvalid), DW'(0));

        wave_on = 1'b0;
        finished = 1'b1;
        report();
    end

endmodule